// File: doc/BRIEF.md
# Single-Line Serial Bus Master (HDQ and 1-Wire)

This block is a memory-mapped master for one open-drain serial line. It can speak either of two single-wire protocols, chosen by a mode bit: HDQ (mode 0) or 1-Wire (mode 1). Software loads a byte to send and writes the control register with a start bit set, plus a direction bit and an optional break bit. The engine then drives the line through a sequence of timed slots. When the transfer ends, the start bit clears itself and an event bit is set in the interrupt status register.

All bit timing is counted in microseconds. A prescaler that divides the clock by the parameter `CLK_PER_US` produces the microsecond ticks. The output `line_pull` enables the pad's pull-down and `line_in` is the level on the line. The line input passes through a two-flop synchronizer before the engine samples it.

A single-bit option shrinks any transfer to one slot, which lets software run bit-level sequences. A break command issues a reset pulse. It then samples the line to record whether a slave answered with a presence pulse.

Top module: `oneline_master`

## Requirements
- R1: After reset, every register reads 0 except the revision register, `irq` is low and `line_pull` is low (line released).
- R2: Offset 0x00 reads the parameter `REV_MAJOR` in bits 7:4 and `REV_MINOR` in bits 3:0. Offset 0x04 is the transmit byte and offset 0x08 is the receive byte.
- R3: Writing offset 0x0C with bit4 (start), bit5 (clock enable) and bit1 (direction) = 0 sends the transmit byte LSB first. In 1-Wire mode each slot lasts 65 µs and pulls the line low for 6 µs to send a 1 or 60 µs to send a 0. At the end, the start bit reads 0 and bit2 of the interrupt status (offset 0x10) is set.
- R4: With direction = 1 in 1-Wire mode, each slot pulls the line low for 6 µs and samples the line 15 µs after the slot starts. Received bits are shifted in LSB first into the receive byte. At the end, interrupt status bit1 is set.
- R5: With bit7 (single) set, a transfer has exactly one slot. A write sends bit0 of the transmit byte. A read stores the bit in bit0 of the receive byte and clears bits 7:1.
- R6: Setting bit2 (break) together with the start bit pulls the line low for 480 µs in 1-Wire mode and samples the line 70 µs after release. Bit3 (presence, read-only) then reads 1 if the line was low at that sample, or 0 if it was not. Interrupt status bit0 is set, and both the break bit and the start bit read 0.
- R7: In HDQ mode (control bit0 = 0), a write slot lasts 190 µs with 40 µs low for a 1 and 120 µs low for a 0. A read slot does not pull the line and samples it 90 µs into the slot. A break pulls the line low for 190 µs.
- R8: Reading offset 0x10 returns the pending event bits and clears them.
- R9: `irq` is high exactly when control bit6 (interrupt enable) is 1 and at least one interrupt status bit is pending.
- R10: Writes to offset 0x04 or 0x0C are ignored while the start bit reads 1.
- R11: A start request written with clock enable = 0 is dropped. The start bit reads 0, the line stays released and no event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for clear-on-read) |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| line_pull | output | 1 | 1 = pull the line low |
| line_in | input | 1 | Sensed line level |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of check are used. Writes are checked by measuring every low pulse on the line. Reads are checked with a slave model that holds the line low during chosen slots. In 1-Wire mode the byte 0xA5 is sent, so adjacent ones and zeros separate the 6 µs and 60 µs pulses and also prove LSB-first order. A slave pattern of 0x3C is read back, which exposes any reversed shift or misplaced sample point. HDQ mode sends 0x5A to confirm the 40/120 µs timing. HDQ reads are run against an idle line and against a held-low line, which tells a missing sample apart from a stuck receive register. Break is run with and without a presence responder, so the presence bit has to take both values. Single-bit transfers use an even transmit byte and a stale receive byte, so a full-byte transfer or unmasked upper bits would show.

// File: rtl/oneline_master.sv
module oneline_master #(
  parameter int CLK_PER_US = 4,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       line_pull,
  input  logic       line_in,
  output logic       irq
);
  localparam int OW_SLOT = 65, OW_LOW1 = 6, OW_LOW0 = 60, OW_RSAMP = 15;
  localparam int OW_BRK_LOW = 480, OW_PRES = 70, OW_BRK_END = 960;
  localparam int HQ_SLOT = 190, HQ_LOW1 = 40, HQ_LOW0 = 120, HQ_RSAMP = 90;
  localparam int HQ_BRK_LOW = 190, HQ_PRES = 20, HQ_BRK_END = 230;
  localparam int CW = $clog2(OW_BRK_END + 1);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [7:0] tx_data, rx_data, txs;
  logic       single, ie, clken, go, pres, init, dir, mode;
  logic [2:0] irq_st, ev;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt, low_t, samp_t, end_t;
  logic [2:0] bitn;
  logic [1:0] sync;
  logic tick, slot_end, sample, last_slot, done;
  logic wr_tx, wr_ctl, rd_clr, start;
  logic unused_bit;

  assign unused_bit = wdata[3];
  assign wr_tx  = wr_en && addr == 5'h04 && !go;
  assign wr_ctl = wr_en && addr == 5'h0C && !go;
  assign rd_clr = rd_en && addr == 5'h10;
  assign start  = wr_ctl && wdata[4] && wdata[5];

  always_comb begin
    if (init) begin
      low_t  = CW'(mode ? OW_BRK_LOW : HQ_BRK_LOW);
      samp_t = low_t + CW'(mode ? OW_PRES : HQ_PRES);
      end_t  = CW'(mode ? OW_BRK_END : HQ_BRK_END);
    end else if (dir) begin
      low_t  = CW'(mode ? OW_LOW1 : 0);
      samp_t = CW'(mode ? OW_RSAMP : HQ_RSAMP);
      end_t  = CW'(mode ? OW_SLOT : HQ_SLOT);
    end else begin
      if (txs[0]) low_t = CW'(mode ? OW_LOW1 : HQ_LOW1);
      else        low_t = CW'(mode ? OW_LOW0 : HQ_LOW0);
      end_t  = CW'(mode ? OW_SLOT : HQ_SLOT);
      samp_t = end_t;
    end
  end

  assign tick      = go && (pre == PW'(CLK_PER_US - 1));
  assign slot_end  = tick && (cnt == end_t - 1'b1);
  assign sample    = tick && (cnt == samp_t);
  assign last_slot = init || single || (bitn == 3'd7);
  assign done      = slot_end && last_slot;
  assign ev        = {done && !init && !dir, done && !init && dir, done && init};
  assign line_pull = go && (cnt < low_t);
  assign irq       = ie && (irq_st != 3'b000);

  always_comb begin
    case (addr)
      5'h00:   rdata = {REV_MAJOR, REV_MINOR};
      5'h04:   rdata = tx_data;
      5'h08:   rdata = rx_data;
      5'h0C:   rdata = {single, ie, clken, go, pres, init, dir, mode};
      5'h10:   rdata = {5'b0, irq_st};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0; rx_data <= '0; txs <= '0;
      {single, ie, clken, go, pres, init, dir, mode} <= '0;
      irq_st <= '0; pre <= '0; cnt <= '0; bitn <= '0; sync <= 2'b11;
    end else begin
      sync   <= {sync[0], line_in};
      irq_st <= (rd_clr ? 3'b000 : irq_st) | ev;
      if (wr_tx) tx_data <= wdata;
      if (wr_ctl) begin
        {single, ie, clken} <= wdata[7:5];
        {init, dir, mode}   <= wdata[2:0];
        go <= start;
        if (start) begin
          pre <= '0; cnt <= '0; bitn <= '0; txs <= tx_data;
          if (wdata[2]) pres <= 1'b0;
        end
      end
      if (go) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) cnt <= slot_end ? '0 : cnt + 1'b1;
        if (sample) begin
          if (init)        pres    <= !sync[1];
          else if (single) rx_data <= {7'b0, sync[1]};
          else             rx_data <= {sync[1], rx_data[7:1]};
        end
        if (slot_end) begin
          txs  <= {1'b0, txs[7:1]};
          bitn <= bitn + 1'b1;
          if (last_slot) begin
            go   <= 1'b0;
            init <= 1'b0;
          end
        end
      end
    end
  end

  // R10
  tx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go) |-> $stable(tx_data));

  // R11
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clken |-> !go);

  // R3
  done_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> (irq_st != 3'b000));

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(go) |-> $stable(rx_data));

  // R6
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> !init);
endmodule

// File: tb/test_oneline_master.sv
`timescale 1ns/1ps
module test_oneline_master;
  localparam int CPU = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic line_pull, line_in, irq;
  int nchk = 0, nfail = 0;
  int run = 0, ncap = 0, hold = 0, rd_idx = 0;
  int widths [16];
  logic prev_low = 1'b0, rd_model = 1'b0, pres_model = 1'b0, force_low = 1'b0;
  logic [7:0] rd_pat = '0;

  always #4 clk = ~clk;

  oneline_master #(.CLK_PER_US(CPU)) i_oneline_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .line_pull(line_pull), .line_in(line_in), .irq(irq));

  assign line_in = !(line_pull || (hold != 0) || force_low);

  always @(negedge clk) begin
    if (hold > 0) hold--;
    if (line_pull && !prev_low && rd_model) begin
      hold = rd_pat[rd_idx] ? 0 : 30 * CPU;
      rd_idx++;
    end
    if (line_pull) run++;
    else if (run != 0) begin
      if (pres_model && run >= 400 * CPU) hold = 150 * CPU;
      if (ncap < 16) widths[ncap] = run;
      ncap++;
      run = 0;
    end
    prev_low = line_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [7:0] d;
    int n = 0;
    do begin rd(5'h0C, d); n++; end while (d[4] && n < 40000);
    chk(!d[4], req, int'(d[4]), 0);
  endtask

  task automatic chk_widths(input string req, input int cnt, input int w []);
    chk(ncap == cnt, req, ncap, cnt);
    for (int i = 0; i < cnt && i < ncap; i++)
      chk(widths[i] == w[i] * CPU, req, widths[i], w[i] * CPU);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(5'h0C, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(5'h10, d); chk(d == 8'h00, "R1 status", d, 0);
    rd(5'h04, d); chk(d == 8'h00, "R1 tx", d, 0);
    rd(5'h08, d); chk(d == 8'h00, "R1 rx", d, 0);
    chk(!irq && !line_pull, "R1 outputs", {irq, line_pull}, 0);
    rd(5'h00, d); chk(d == 8'h21, "R2 revision", d, 8'h21);
  endtask

  task automatic t_ow_write;
    logic [7:0] d;
    wr(5'h04, 8'hA5);
    ncap = 0;
    wr(5'h0C, 8'h71);
    wr(5'h04, 8'h00);
    wr(5'h0C, 8'h00);
    wait_done("R3 go clears");
    chk_widths("R3 pulses", 8, '{6, 60, 6, 60, 60, 6, 60, 6});
    rd(5'h04, d); chk(d == 8'hA5, "R10 tx kept", d, 8'hA5);
    rd(5'h0C, d); chk(d == 8'h61, "R10 ctrl kept", d, 8'h61);
    chk(irq == 1'b1, "R9 irq on", irq, 1);
    rd(5'h10, d); chk(d == 8'h04, "R3 tx flag", d, 4);
    rd(5'h10, d); chk(d == 8'h00, "R8 cleared", d, 0);
    chk(irq == 1'b0, "R9 irq off", irq, 0);
  endtask

  task automatic t_ow_read;
    logic [7:0] d;
    rd_pat = 8'h3C; rd_idx = 0; rd_model = 1'b1; ncap = 0;
    wr(5'h0C, 8'h73);
    wait_done("R4 go clears");
    rd_model = 1'b0;
    chk_widths("R4 pulses", 8, '{6, 6, 6, 6, 6, 6, 6, 6});
    rd(5'h08, d); chk(d == 8'h3C, "R4 rx byte", d, 8'h3C);
    rd(5'h10, d); chk(d == 8'h02, "R4 rx flag", d, 2);
  endtask

  task automatic t_single;
    logic [7:0] d;
    wr(5'h04, 8'hFE);
    ncap = 0;
    wr(5'h0C, 8'hB1);
    wait_done("R5 write done");
    chk_widths("R5 one slot", 1, '{60});
    chk(irq == 1'b0, "R9 masked", irq, 0);
    rd(5'h10, d); chk(d == 8'h04, "R5 tx flag", d, 4);
    ncap = 0;
    wr(5'h0C, 8'hB3);
    wait_done("R5 read done");
    chk(ncap == 1, "R5 one read slot", ncap, 1);
    rd(5'h08, d); chk(d == 8'h01, "R5 rx bit0", d, 1);
    rd(5'h10, d); chk(d == 8'h02, "R5 rx flag", d, 2);
  endtask

  task automatic t_break;
    logic [7:0] d;
    pres_model = 1'b1; ncap = 0;
    wr(5'h0C, 8'h75);
    wait_done("R6 go clears");
    chk_widths("R6 reset pulse", 1, '{480});
    rd(5'h0C, d); chk(d == 8'h69, "R6 presence set", d, 8'h69);
    rd(5'h10, d); chk(d == 8'h01, "R6 timeout flag", d, 1);
    pres_model = 1'b0;
    repeat (200 * CPU) @(negedge clk);
    wr(5'h0C, 8'h75);
    wait_done("R6 second break");
    rd(5'h0C, d); chk(d == 8'h61, "R6 no presence", d, 8'h61);
    rd(5'h10, d); chk(d == 8'h01, "R6 timeout flag 2", d, 1);
  endtask

  task automatic t_hdq;
    logic [7:0] d;
    wr(5'h04, 8'h5A);
    ncap = 0;
    wr(5'h0C, 8'h70);
    wait_done("R7 write done");
    chk_widths("R7 write pulses", 8, '{120, 40, 120, 40, 40, 120, 40, 120});
    rd(5'h10, d); chk(d == 8'h04, "R7 tx flag", d, 4);
    ncap = 0;
    wr(5'h0C, 8'h72);
    wait_done("R7 read done");
    chk(ncap == 0, "R7 read no pull", ncap, 0);
    rd(5'h08, d); chk(d == 8'hFF, "R7 read high", d, 8'hFF);
    force_low = 1'b1;
    wr(5'h0C, 8'h72);
    wait_done("R7 read2 done");
    force_low = 1'b0;
    rd(5'h08, d); chk(d == 8'h00, "R7 read low", d, 0);
    ncap = 0;
    wr(5'h0C, 8'h74);
    wait_done("R7 break done");
    chk_widths("R7 break pulse", 1, '{190});
    rd(5'h10, d); chk(d == 8'h03, "R7 flags", d, 3);
  endtask

  task automatic t_clk_off;
    logic [7:0] d;
    ncap = 0;
    wr(5'h0C, 8'h11);
    rd(5'h0C, d); chk(d == 8'h01, "R11 go dropped", d, 1);
    repeat (100 * CPU) @(negedge clk);
    chk(ncap == 0 && !line_pull, "R11 line idle", ncap, 0);
    rd(5'h10, d); chk(d == 8'h00, "R11 no event", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset; t_ow_write; t_ow_read; t_single; t_break; t_hdq; t_clk_off;
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule